// File: doc/BRIEF.md
# Lowest-Priority Destination Arbiter

This block picks one target among N interrupt-controller cores for an interrupt sent in lowest-priority delivery mode. Each core presents three things: a bit saying whether the message's destination matched it, and the inputs from which its arbitration priority is formed. Those inputs are its task priority, its highest in-service vector and its highest requested vector, each vector with a valid bit.

From these the block forms a per-core arbitration class, which is the upper nibble of the arbitration priority. Among the matching cores it grants the one with the numerically smallest class. The grant comes out as a one-hot vector, as a binary index and as a valid flag.

Message decoding, logical destination matching and the delivery handshake belong to neighbouring logic. A parameter selects either a registered output stage (the default) or a purely combinational path.

Top module: `lpa_arbiter`

## Requirements
- R1: Only a core whose match bit is set can be granted. When no match bit is set, grant_vld_o is 0, grant_onehot_o is all zeros and grant_idx_o is 0.
- R2: A core's arbitration class is derived from three class nibbles: the task priority's upper nibble, the upper nibble of the in-service vector, and the upper nibble of the requested vector. An absent vector (valid bit 0) contributes class 0. If the task-priority nibble is at least the in-service nibble and at least the requested nibble, the class is the task-priority nibble. Otherwise it is the larger of the in-service and requested nibbles. The result equals the maximum of the three.
- R3: A matching core wins over every matching core whose class is strictly larger.
- R4: Among matching cores with equal smallest class, the lowest-indexed core wins.
- R5: The lower nibble of the task priority and the lower nibbles of both vectors have no effect on the selection.
- R6: When grant_vld_o is 1, grant_onehot_o has exactly one bit set, at position grant_idx_o.
- R7: With REGISTERED=1, the outputs reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, grant_vld_o, grant_onehot_o and grant_idx_o are 0.
- R8: The core count is the parameter N (default 4), and grant_idx_o is ceil(log2 N) bits wide, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | N | Destination-match bit per core |
| tpr_i | input | 8*N | Task priority per core, core k in bits [8k+7:8k] |
| isr_vec_i | input | 8*N | Highest in-service vector per core |
| isr_vld_i | input | N | In-service vector present |
| irr_vec_i | input | 8*N | Highest requested vector per core |
| irr_vld_i | input | N | Requested vector present |
| grant_onehot_o | output | N | One-hot winning core |
| grant_idx_o | output | ceil(log2 N) | Index of winning core |
| grant_vld_o | output | 1 | A winner exists |

## Verification
Three properties are checked by assertions on every cycle. The one-hot output agrees with the valid flag and with the index. The combinational selection is valid exactly when some core matches. Any registered grant points at a core that matched one cycle earlier.

The remaining behaviours can only be shown by the bench's scenarios:
- the priority order itself, meaning the smallest class wins;
- the lowest-index tie break;
- how each of the three inputs raises the class;
- the blindness to lower nibbles;
- the one-cycle latency of the output.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned CLS_W = 4;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/lpa_prio_derive.sv
module lpa_prio_derive
  import lpa_pkg::*;
(
  input  vec_t tpr_i,
  input  vec_t isr_vec_i,
  input  logic isr_vld_i,
  input  vec_t irr_vec_i,
  input  logic irr_vld_i,
  output vec_t apr_o,
  output cls_t cls_o
);
  cls_t tpr_c, isr_c, irr_c;

  assign tpr_c = cls_of(tpr_i);
  assign isr_c = isr_vld_i ? cls_of(isr_vec_i) : '0;
  assign irr_c = irr_vld_i ? cls_of(irr_vec_i) : '0;

  // Full value kept only when task priority dominates; else class-only.
  always_comb begin
    if (tpr_c >= isr_c) begin
      if (tpr_c >= irr_c) apr_o = tpr_i;
      else                apr_o = {irr_c, {(VEC_W-CLS_W){1'b0}}};
    end else begin
      if (isr_c >= irr_c) apr_o = {isr_c, {(VEC_W-CLS_W){1'b0}}};
      else                apr_o = {irr_c, {(VEC_W-CLS_W){1'b0}}};
    end
  end

  assign cls_o = cls_of(apr_o);
endmodule

// File: rtl/lpa_select.sv
module lpa_select
  import lpa_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]       match_i,
  input  logic [N*CLS_W-1:0] cls_i,
  output logic [N-1:0]       sel_onehot_o,
  output logic [IW-1:0]      sel_idx_o,
  output logic               sel_vld_o
);
  cls_t best_cls;

  // Index-order scan: strict less-than keeps the earlier core on ties.
  always_comb begin
    sel_vld_o = 1'b0;
    sel_idx_o = '0;
    best_cls  = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && (!sel_vld_o || cls_i[i*CLS_W +: CLS_W] < best_cls)) begin
        sel_vld_o = 1'b1;
        sel_idx_o = IW'(i);
        best_cls  = cls_i[i*CLS_W +: CLS_W];
      end
    end
  end

  always_comb begin
    sel_onehot_o = '0;
    if (sel_vld_o) sel_onehot_o[sel_idx_o] = 1'b1;
  end
endmodule

// File: rtl/lpa_out_stage.sv
module lpa_out_stage #(
  parameter int unsigned N          = 4,
  parameter int unsigned IW         = 2,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  onehot_i,
  input  logic [IW-1:0] idx_i,
  input  logic          vld_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          onehot_o <= '0;
          idx_o    <= '0;
          vld_o    <= 1'b0;
        end else begin
          onehot_o <= onehot_i;
          idx_o    <= idx_i;
          vld_o    <= vld_i;
        end
      end
    end else begin : g_comb
      assign onehot_o = onehot_i;
      assign idx_o    = idx_i;
      assign vld_o    = vld_i;
    end
  endgenerate
endmodule

// File: rtl/lpa_arbiter.sv
module lpa_arbiter
  import lpa_pkg::*;
#(
  parameter int unsigned N          = 4,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       match_i,
  input  logic [N*VEC_W-1:0] tpr_i,
  input  logic [N*VEC_W-1:0] isr_vec_i,
  input  logic [N-1:0]       isr_vld_i,
  input  logic [N*VEC_W-1:0] irr_vec_i,
  input  logic [N-1:0]       irr_vld_i,
  output logic [N-1:0]       grant_onehot_o,
  output logic [IW-1:0]      grant_idx_o,
  output logic               grant_vld_o
);
  logic [N*VEC_W-1:0] apr;
  logic [N*CLS_W-1:0] cls;
  logic [N-1:0]       sel_onehot;
  logic [IW-1:0]      sel_idx;
  logic               sel_vld;

  generate
    for (genvar k = 0; k < N; k++) begin : g_core
      lpa_prio_derive u_derive (
        .tpr_i     (tpr_i[k*VEC_W +: VEC_W]),
        .isr_vec_i (isr_vec_i[k*VEC_W +: VEC_W]),
        .isr_vld_i (isr_vld_i[k]),
        .irr_vec_i (irr_vec_i[k*VEC_W +: VEC_W]),
        .irr_vld_i (irr_vld_i[k]),
        .apr_o     (apr[k*VEC_W +: VEC_W]),
        .cls_o     (cls[k*CLS_W +: CLS_W])
      );
    end
  endgenerate

  lpa_select #(.N(N), .IW(IW)) u_select (
    .match_i      (match_i),
    .cls_i        (cls),
    .sel_onehot_o (sel_onehot),
    .sel_idx_o    (sel_idx),
    .sel_vld_o    (sel_vld)
  );

  lpa_out_stage #(.N(N), .IW(IW), .REGISTERED(REGISTERED)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .onehot_i (sel_onehot),
    .idx_i    (sel_idx),
    .vld_i    (sel_vld),
    .onehot_o (grant_onehot_o),
    .idx_o    (grant_idx_o),
    .vld_o    (grant_vld_o)
  );

  // R6
  onehot_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_onehot_o) && (grant_vld_o == (|grant_onehot_o)));

  // R6
  idx_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> grant_onehot_o[grant_idx_o]);

  // R1
  sel_any_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_vld == (|match_i));

  // R1
  sel_in_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_onehot & ~match_i) == '0);

  generate
    if (REGISTERED) begin : g_reg_chk
      // R1 R7
      grant_was_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_vld_o |-> ((grant_onehot_o & $past(match_i)) != '0));
    end
  endgenerate
endmodule

// File: tb/sim_lpa_arbiter.sv
`timescale 1ns/1ps
module sim_lpa_arbiter;
  localparam int N = 4;
  localparam int IW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]   match;
  logic [N*8-1:0] tpr, isr_vec, irr_vec;
  logic [N-1:0]   isr_vld, irr_vld;
  logic [N-1:0]   g_oh;
  logic [IW-1:0]  g_idx;
  logic           g_vld;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpa_arbiter #(.N(N), .REGISTERED(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .match_i(match), .tpr_i(tpr),
    .isr_vec_i(isr_vec), .isr_vld_i(isr_vld), .irr_vec_i(irr_vec),
    .irr_vld_i(irr_vld), .grant_onehot_o(g_oh), .grant_idx_o(g_idx),
    .grant_vld_o(g_vld)
  );

  task automatic clear_all();
    match = '0; tpr = '0; isr_vec = '0; irr_vec = '0; isr_vld = '0; irr_vld = '0;
  endtask

  task automatic set_core(int k, bit m, logic [7:0] t, logic [7:0] is, bit isv,
                          logic [7:0] ir, bit irv);
    match[k] = m; tpr[k*8 +: 8] = t;
    isr_vec[k*8 +: 8] = is; isr_vld[k] = isv;
    irr_vec[k*8 +: 8] = ir; irr_vld[k] = irv;
  endtask

  // Expected grant index from the requirements; -1 means none.
  function automatic int ref_winner();
    int best = -1;
    int bc = 0;
    for (int k = 0; k < N; k++) begin
      int c = tpr[k*8+4 +: 4];
      if (isr_vld[k] && isr_vec[k*8+4 +: 4] > c) c = isr_vec[k*8+4 +: 4];
      if (irr_vld[k] && irr_vec[k*8+4 +: 4] > c) c = irr_vec[k*8+4 +: 4];
      if (match[k] && (best < 0 || c < bc)) begin best = k; bc = c; end
    end
    return best;
  endfunction

  task automatic expect_grant(string req, int exp);
    logic [N-1:0] eoh = (exp >= 0) ? (N'(1) << exp) : '0;
    bit ev = (exp >= 0);
    int ei = (exp >= 0) ? exp : 0;
    checks++;
    if (g_vld !== ev || g_oh !== eoh || int'(g_idx) !== ei) begin
      errors++;
      $display("FAIL %s: got vld=%0b oh=%b idx=%0d expected vld=%0b oh=%b idx=%0d",
               req, g_vld, g_oh, g_idx, ev, eoh, ei);
    end
  endtask

  // Drive after an edge, let the next edge capture, sample off-edge.
  task automatic step_and_check(string req, int exp);
    @(posedge clk); #1;
    expect_grant(req, exp);
  endtask

  task automatic t_reset();
    clear_all();
    set_core(0, 1, 8'h10, 0, 0, 0, 0);
    rst_ni = 1'b0;
    #(CLK_PERIOD*2);
    expect_grant("R7 reset", -1);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_no_match();
    clear_all();
    set_core(0, 0, 8'h00, 0, 0, 0, 0);
    set_core(2, 0, 8'h00, 0, 0, 0, 0);
    step_and_check("R1 no match", -1);
  endtask

  task automatic t_single();
    clear_all();
    for (int k = 0; k < N; k++) set_core(k, 0, 8'h00, 0, 0, 0, 0);
    set_core(3, 1, 8'hF0, 0, 0, 0, 0);
    step_and_check("R1 single match", 3);
  endtask

  task automatic t_min_class();
    clear_all();
    set_core(0, 1, 8'h50, 0, 0, 0, 0);
    set_core(1, 1, 8'h30, 0, 0, 0, 0);
    set_core(2, 1, 8'h20, 0, 0, 0, 0);
    set_core(3, 0, 8'h00, 0, 0, 0, 0);
    step_and_check("R3 smallest class wins", 2);
    if (ref_winner() != 2) $display("note: model mismatch");
  endtask

  task automatic t_tie();
    clear_all();
    set_core(0, 0, 8'h10, 0, 0, 0, 0);
    set_core(1, 1, 8'h40, 0, 0, 0, 0);
    set_core(2, 1, 8'h40, 0, 0, 0, 0);
    set_core(3, 1, 8'h40, 0, 0, 0, 0);
    step_and_check("R4 tie lowest index", 1);
  endtask

  task automatic t_subclass();
    clear_all();
    // Core 1 has lower full value but same class; core 0 keeps grant.
    set_core(0, 1, 8'h4F, 8'h1E, 1, 8'h2D, 1);
    set_core(1, 1, 8'h40, 0, 0, 0, 0);
    step_and_check("R5 subclass ignored", 0);
    set_core(0, 1, 8'h30, 8'h3F, 1, 0, 0);
    set_core(1, 1, 8'h2F, 8'h2F, 1, 8'h2F, 1);
    step_and_check("R5 subclass ignored 2", 1);
  endtask

  task automatic t_derive();
    clear_all();
    set_core(0, 1, 8'h20, 8'h70, 1, 0, 0);
    set_core(1, 1, 8'h40, 0, 0, 0, 0);
    step_and_check("R2 in-service raises class", 1);
    set_core(1, 1, 8'h10, 0, 0, 8'h91, 1);
    step_and_check("R2 requested raises class", 0);
    set_core(1, 1, 8'h10, 0, 0, 8'h91, 0);
    step_and_check("R2 absent vector ignored", 1);
    set_core(0, 1, 8'h20, 8'hE0, 0, 8'hE0, 0);
    set_core(1, 1, 8'h30, 0, 0, 0, 0);
    step_and_check("R2 absent both vectors", 0);
    set_core(0, 1, 8'h80, 8'h60, 1, 8'h70, 1);
    set_core(1, 1, 8'h70, 8'h20, 1, 8'h50, 1);
    step_and_check("R2 task priority dominates", ref_winner());
  endtask

  task automatic t_latency();
    clear_all();
    set_core(2, 1, 8'h10, 0, 0, 0, 0);
    step_and_check("R7 setup", 2);
    set_core(2, 0, 8'h10, 0, 0, 0, 0);
    set_core(1, 1, 8'h10, 0, 0, 0, 0);
    #1;
    expect_grant("R7 holds until edge", 2);
    step_and_check("R7 updates after edge", 1);
  endtask

  task automatic t_async_reset();
    clear_all();
    set_core(0, 1, 8'h00, 0, 0, 0, 0);
    step_and_check("R7 pre-reset", 0);
    #2; rst_ni = 1'b0; #1;
    expect_grant("R7 async clear", -1);
    @(negedge clk); rst_ni = 1'b1;
    step_and_check("R7 after release", 0);
  endtask

  task automatic t_all_top();
    clear_all();
    for (int k = 0; k < N; k++) set_core(k, 1, 8'hF0, 8'hF5, 1, 8'hFA, 1);
    step_and_check("R4 R8 all max class", 0);
    set_core(N-1, 1, 8'hE0, 0, 0, 0, 0);
    step_and_check("R8 last index reachable", N-1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_match();
    t_single();
    t_min_class();
    t_tie();
    t_subclass();
    t_derive();
    t_latency();
    t_async_reset();
    t_all_top();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule